// File: doc/BRIEF.md
# TDM Serial Input Capture

This block takes in eight serial time-division streams at the same time. Each frame of a stream holds 32 channels of eight bits. One bit cell lasts two clock periods, so one frame is 512 clock cycles long. A single free-running position counter sets all timing. An active-low frame pulse that is sampled low forces the counter back to the start of the frame. Each stream has its own shift register, which turns the serial bits into bytes. At the end of every channel, all eight bytes go into a 256-entry byte store. Each entry is found by stream number and channel number.

The store is read-only from outside, through a registered read port with one cycle of latency. The block also gives out its current channel number, bit index and half-cell phase, so that a neighbouring output path can run in step with the input frame.

Top module: `tdm_in_capture`

## Requirements
- R1: When `rst_n` is low at a rising edge, the next cycle shows `chan_idx` = 0, `bit_idx` = 7, `cell_half` = 0 and `rd_data` = 0. Bytes already in the store are kept.
- R2: Without a frame pulse, the position advances by one half cell each cycle. `cell_half` goes 0 then 1. `bit_idx` steps down from 7 to 0 every two cycles. `chan_idx` goes up by one every 16 cycles. After the second half of channel 31 bit 0 comes the first half of channel 0 bit 7, so one frame is 512 cycles.
- R3: When `frame_n` is low at a rising edge, the next cycle is channel 0, bit 7, first half, whatever the position was before.
- R4: Bits are sent most significant first. The cell with `bit_idx` = 7 carries bit 7 of the byte.
- R5: Each stream's bit is sampled at the rising edge that ends the first half of its cell (`cell_half` = 0). The line level during the second half has no effect on the stored byte.
- R6: A channel's byte is written at the rising edge that ends the second half of its bit 0 cell. The byte goes to address stream*32 + channel, with the stream in `rd_addr[7:5]` and the channel in `rd_addr[4:0]`.
- R7: `rd_data` in cycle t+1 is the stored byte at the `rd_addr` value of cycle t. If that location is written at the same edge, the old byte is returned.
- R8: All eight streams are captured in parallel. Stream s only ever writes the 32 locations whose address has s in bits 7:5.
- R9: If a frame pulse cuts a channel short before its bit 0 cell ends, that channel is not written, and its location keeps the byte it held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two periods per bit cell |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Frame alignment pulse, active low |
| ser_in | input | 8 | One serial data line per stream |
| rd_addr | input | 8 | Store read address {stream, channel} |
| rd_data | output | 8 | Registered read data |
| chan_idx | output | 5 | Current channel number |
| bit_idx | output | 3 | Current bit index within the channel (7 first) |
| cell_half | output | 1 | 0 in the first half of a bit cell, 1 in the second |

## Verification
The position outputs take effect one edge after the inputs that cause them. A frame pulse or reset seen at edge E shows position zero in the cycle that starts at E. A channel byte is stored at the edge that ends tick 15 of its channel. Because of the registered read port, an address presented in cycle t returns its byte in cycle t+1. The bench reference model steps once per cycle at the falling edge, in the same order as the hardware: it reads first, then samples, then writes, then advances. Directed reads are issued only in channel ticks 3 to 4, where no write can land, so their expected value is fixed.

// File: rtl/tdm_cap_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the TDM input capture block.
// Assumes the channel count and the byte width are powers of two.
package tdm_cap_pkg;

    localparam int unsigned DEF_STREAMS = 8;
    localparam int unsigned DEF_CHANS   = 32;
    localparam int unsigned DEF_BYTE_W  = 8;

    // Which half of a two-clock bit cell is current
    typedef enum logic {
        HALF_FIRST  = 1'b0,
        HALF_SECOND = 1'b1
    } cell_half_e;

endpackage

// File: rtl/tdm_cap_timebase.sv
`timescale 1ns/1ps
// Frame position counter: one tick per clock, two ticks per bit cell,
// 2*BYTE_W ticks per channel. An active-low frame pulse seen at an edge
// restarts the frame. Derives the sample and end-of-channel strobes.
// Assumes CHANS and BYTE_W are powers of two.
module tdm_cap_timebase #(
    parameter  int unsigned CHANS  = tdm_cap_pkg::DEF_CHANS,
    parameter  int unsigned BYTE_W = tdm_cap_pkg::DEF_BYTE_W,
    localparam int unsigned CH_W   = $clog2(CHANS),
    localparam int unsigned BIT_W  = $clog2(BYTE_W),
    localparam int unsigned TICK_W = CH_W + BIT_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_n,
    output logic [CH_W-1:0]         chan,
    output logic [BIT_W-1:0]        bit_idx,
    output tdm_cap_pkg::cell_half_e half,
    output logic                    sample_en,
    output logic                    chan_end
);
    import tdm_cap_pkg::*;

    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(CHANS * BYTE_W * 2 - 1);

    logic [TICK_W-1:0] tick;

    // Advance the frame position, restarting on reset or frame pulse
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_n) begin
            tick <= '0;
        end else if (tick == LAST_TICK) begin
            tick <= '0;
        end else begin
            tick <= tick + 1'b1;
        end
    end

    // Split the tick into channel, bit (counting down) and half
    always_comb begin
        chan      = tick[TICK_W-1 -: CH_W];
        bit_idx   = ~tick[BIT_W:1];
        half      = cell_half_e'(tick[0]);
        sample_en = (half == HALF_FIRST);
        chan_end  = &tick[BIT_W:0];
    end

endmodule

// File: rtl/tdm_cap_lane.sv
`timescale 1ns/1ps
// Serial-to-parallel converter for one stream. Shifts in one bit per
// strobe, most significant bit first; the assembled byte is valid when
// the last strobe of a channel has been taken.
module tdm_cap_lane #(
    parameter int unsigned BYTE_W = tdm_cap_pkg::DEF_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              ser,
    output logic [BYTE_W-1:0] word
);

    // Shift the sampled line level into the low end of the byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (sample_en) begin
            word <= {word[BYTE_W-2:0], ser};
        end
    end

endmodule

// File: rtl/tdm_cap_store.sv
`timescale 1ns/1ps
// Byte store: one bank of CHANS bytes per stream, all banks written in
// the same cycle at the same channel. A registered read port returns the
// byte at {stream, channel}; a collision with a write returns old data.
// Assumes STREAMS and CHANS are powers of two, STREAMS >= 2.
module tdm_cap_store #(
    parameter  int unsigned STREAMS = tdm_cap_pkg::DEF_STREAMS,
    parameter  int unsigned CHANS   = tdm_cap_pkg::DEF_CHANS,
    parameter  int unsigned BYTE_W  = tdm_cap_pkg::DEF_BYTE_W,
    localparam int unsigned CH_W    = $clog2(CHANS),
    localparam int unsigned S_W     = $clog2(STREAMS),
    localparam int unsigned ADDR_W  = S_W + CH_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [CH_W-1:0]             wr_chan,
    input  logic [STREAMS*BYTE_W-1:0]   wr_words,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [BYTE_W-1:0]           rd_data
);

    logic [BYTE_W-1:0] bank_q [STREAMS];
    logic [CH_W-1:0]   rd_chan;
    logic [S_W-1:0]    rd_strm;

    assign rd_chan = rd_addr[CH_W-1:0];
    assign rd_strm = rd_addr[ADDR_W-1 -: S_W];

    for (genvar g = 0; g < STREAMS; g++) begin : g_bank
        logic [BYTE_W-1:0] mem [CHANS];

        // Store this stream's byte at the channel that just ended
        always_ff @(posedge clk) begin
            if (wr_en) begin
                mem[wr_chan] <= wr_words[g*BYTE_W +: BYTE_W];
            end
        end

        assign bank_q[g] = mem[rd_chan];
    end

    // Register the selected bank's output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= bank_q[rd_strm];
        end
    end

endmodule

// File: rtl/tdm_in_capture.sv
`timescale 1ns/1ps
// TDM serial input capture: STREAMS serial lines, CHANS channels of
// BYTE_W bits per frame, two clocks per bit cell. Bits are sampled in
// the middle of each cell and every channel's bytes are stored at its
// end. Exposes the frame position for a companion output path.
module tdm_in_capture #(
    parameter  int unsigned STREAMS = tdm_cap_pkg::DEF_STREAMS,
    parameter  int unsigned CHANS   = tdm_cap_pkg::DEF_CHANS,
    parameter  int unsigned BYTE_W  = tdm_cap_pkg::DEF_BYTE_W,
    localparam int unsigned CH_W    = $clog2(CHANS),
    localparam int unsigned BIT_W   = $clog2(BYTE_W),
    localparam int unsigned ADDR_W  = $clog2(STREAMS) + CH_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_n,
    input  logic [STREAMS-1:0]  ser_in,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [BYTE_W-1:0]   rd_data,
    output logic [CH_W-1:0]     chan_idx,
    output logic [BIT_W-1:0]    bit_idx,
    output logic                cell_half
);
    import tdm_cap_pkg::*;

    cell_half_e                 half_e;
    logic                       sample_en;
    logic                       chan_end;
    logic                       wr_en;
    logic [STREAMS*BYTE_W-1:0]  words;

    tdm_cap_timebase #(
        .CHANS  (CHANS),
        .BYTE_W (BYTE_W)
    ) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .chan      (chan_idx),
        .bit_idx   (bit_idx),
        .half      (half_e),
        .sample_en (sample_en),
        .chan_end  (chan_end)
    );

    for (genvar s = 0; s < STREAMS; s++) begin : g_lane
        tdm_cap_lane #(
            .BYTE_W (BYTE_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .sample_en (sample_en),
            .ser       (ser_in[s]),
            .word      (words[s*BYTE_W +: BYTE_W])
        );
    end

    // Writes only happen outside reset, at the end of a channel
    assign wr_en     = chan_end & rst_n;
    assign cell_half = half_e;

    tdm_cap_store #(
        .STREAMS (STREAMS),
        .CHANS   (CHANS),
        .BYTE_W  (BYTE_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_chan  (chan_idx),
        .wr_words (words),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/tdm_in_capture_chk.sv
`timescale 1ns/1ps
// Protocol checker for tdm_in_capture: frame position sequencing, frame
// restart, write timing and read-port stability. Bound to the top.
module tdm_in_capture_chk #(
    parameter  int unsigned CHANS  = 32,
    parameter  int unsigned BYTE_W = 8,
    parameter  int unsigned ADDR_W = 8,
    localparam int unsigned CH_W   = $clog2(CHANS),
    localparam int unsigned BIT_W  = $clog2(BYTE_W),
    localparam int unsigned TICK_W = CH_W + BIT_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_n,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [BYTE_W-1:0] rd_data,
    input logic [CH_W-1:0]   chan_idx,
    input logic [BIT_W-1:0]  bit_idx,
    input logic              cell_half,
    input logic              wr_en
);
    logic [TICK_W-1:0] pos_seen;
    logic [TICK_W-1:0] pos_succ;

    // Rebuild the linear frame position from the exposed outputs
    assign pos_seen = {chan_idx, ~bit_idx, cell_half};
    assign pos_succ = pos_seen + 1'b1;

    p_reset_pos_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pos_seen == '0) && (rd_data == '0));

    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_n |=> pos_seen == $past(pos_succ));

    p_frame_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> pos_seen == '0);

    p_write_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> &pos_seen[BIT_W:0]);

    p_write_each_channel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        &pos_seen[BIT_W:0] |-> wr_en);

    p_read_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $stable(rd_addr) && !$past(wr_en) |=> $stable(rd_data));

endmodule

bind tdm_in_capture tdm_in_capture_chk #(
    .CHANS  (CHANS),
    .BYTE_W (BYTE_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .chan_idx  (chan_idx),
    .bit_idx   (bit_idx),
    .cell_half (cell_half),
    .wr_en     (wr_en)
);

// File: tb/tb_tdm_in_capture.sv
`timescale 1ns/1ps
// Bench for tdm_in_capture: a behavioural per-cycle model stepped at the
// falling edge, compared against the outputs on every clock, plus
// directed reads of known bytes.
module tb_tdm_in_capture;
    localparam int STREAMS = 8;
    localparam int CHANS   = 32;
    localparam int FRAME   = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_n = 1'b1;
    logic [7:0] ser_in = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [4:0] chan_idx;
    logic [2:0] bit_idx;
    logic       cell_half;

    always #2.5 clk = ~clk;

    tdm_in_capture dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ser_in(ser_in),
        .rd_addr(rd_addr), .rd_data(rd_data), .chan_idx(chan_idx),
        .bit_idx(bit_idx), .cell_half(cell_half)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Stimulus controls, changed just after rising edges
    bit         ctl_rst = 1;
    bit         ctl_auto_frame = 1;
    bit         ctl_glitch = 0;
    bit         ctl_sweep = 0;
    int         ctl_pulse_at = -1;
    logic [7:0] ctl_addr = '0;

    // Reference model state
    int    m_tick = 0;
    bit    m_known = 0;
    string pos_tag = "R1";
    int    m_rd = 0;
    bit    m_rdv = 0;
    int    m_fr = 0;
    int    exp_mem[256];
    bit    exp_ok[256];
    int    sent[256];
    int    samp[STREAMS];
    int    sweep_n = 0;

    function automatic int src_byte(int fr, int s, int ch);
        return ((fr * 53 + s * 29 + ch * 7 + 11) ^ (s << 4)) & 255;
    endfunction

    task automatic check_eq(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Per-cycle compare, drive and model step
    initial begin
        for (int i = 0; i < 256; i++) begin
            exp_ok[i] = 0;
            sent[i]   = -1;
        end
        forever begin
            @(negedge clk);
            if (m_known) begin
                check_eq(pos_tag, "channel", int'(chan_idx), m_tick / 16);
                check_eq(pos_tag, "bit index", int'(bit_idx), 7 - (m_tick % 16) / 2);
                check_eq(pos_tag, "cell half", int'(cell_half), m_tick % 2);
                if (m_rdv) check_eq("R7", "read data", int'(rd_data), m_rd);
            end
            rst_n   = !ctl_rst;
            frame_n = 1'b1;
            if (ctl_auto_frame && m_tick == FRAME - 1) frame_n = 1'b0;
            if (ctl_pulse_at >= 0 && m_tick == ctl_pulse_at) begin
                frame_n = 1'b0;
                ctl_pulse_at = -1;
            end
            for (int s = 0; s < STREAMS; s++) begin
                int b;
                b = (src_byte(m_fr, s, m_tick / 16) >> (7 - (m_tick % 16) / 2)) & 1;
                if (ctl_glitch && (m_tick % 2 == 1)) b = b ^ 1;
                ser_in[s] = b[0];
            end
            if (ctl_sweep) begin
                rd_addr = 8'(sweep_n * 29 + 3);
                sweep_n++;
            end else begin
                rd_addr = ctl_addr;
            end
            if (!rst_n) begin
                m_tick  = 0;
                m_rd    = 0;
                m_rdv   = 1;
                m_known = 1;
                pos_tag = "R1";
            end else begin
                int ch;
                ch    = m_tick / 16;
                m_rd  = exp_mem[rd_addr];
                m_rdv = exp_ok[rd_addr];
                if (m_tick % 2 == 0)
                    for (int s = 0; s < STREAMS; s++)
                        samp[s] = ((samp[s] << 1) | int'(ser_in[s])) & 255;
                if (m_tick % 16 == 15)
                    for (int s = 0; s < STREAMS; s++) begin
                        exp_mem[s * 32 + ch] = samp[s];
                        exp_ok[s * 32 + ch]  = 1;
                        sent[s * 32 + ch]    = src_byte(m_fr, s, ch);
                    end
                if (!frame_n) begin
                    pos_tag = (m_tick == FRAME - 1) ? "R2" : "R3";
                    m_tick  = 0;
                    m_fr++;
                end else begin
                    pos_tag = "R2";
                    m_tick  = (m_tick + 1) % FRAME;
                    if (m_tick == 0) m_fr++;
                end
            end
        end
    end

    // Directed read in a window free of writes; expects the sent byte
    task automatic read_chk(int addr, string tag);
        do begin
            @(posedge clk);
            #1;
        end while (m_tick % 16 != 3);
        ctl_addr = 8'(addr);
        @(negedge clk);
        @(negedge clk);
        check_eq(tag, $sformatf("byte at address %0d", addr), int'(rd_data), sent[addr]);
    endtask

    task automatic wait_tick(int t);
        do begin
            @(posedge clk);
            #1;
        end while (m_tick != t);
    endtask

    initial begin
        int prev;
        repeat (3) @(posedge clk);
        #1 ctl_rst = 0;
        @(negedge clk);
        check_eq("R1", "reset channel", int'(chan_idx), 0);
        check_eq("R1", "reset bit index", int'(bit_idx), 7);
        check_eq("R1", "reset half", int'(cell_half), 0);
        check_eq("R1", "reset read data", int'(rd_data), 0);

        // Normal capture over two frames: MSB order, address map, streams
        repeat (2 * FRAME + 20) @(posedge clk);
        read_chk(0, "R4");
        read_chk(31, "R6");
        read_chk(7 * 32 + 31, "R8");
        read_chk(5 * 32 + 17, "R8");
        read_chk(3 * 32 + 9, "R6");

        // Second half of every cell inverted: must not reach the store
        #1 ctl_glitch = 1;
        repeat (FRAME + 40) @(posedge clk);
        read_chk(2 * 32 + 20, "R5");
        read_chk(6 * 32 + 1, "R5");
        read_chk(1 * 32 + 0, "R5");
        #1 ctl_glitch = 0;

        // Frame pulse in the middle of channel 12
        wait_tick(100);
        ctl_pulse_at = 200;
        wait_tick(201 - 200);
        prev = sent[4 * 32 + 12];
        read_chk(4 * 32 + 12, "R9");
        check_eq("R9", "interrupted channel kept", sent[4 * 32 + 12], prev);

        // Read port swept every cycle, including write collisions
        #1 ctl_sweep = 1;
        repeat (700) @(posedge clk);
        #1 ctl_sweep = 0;

        // Counter must wrap by itself with no frame pulses
        ctl_auto_frame = 0;
        repeat (FRAME + 300) @(posedge clk);
        #1 ctl_auto_frame = 1;

        // Reset in mid-frame; stored bytes stay
        wait_tick(300);
        ctl_rst = 1;
        repeat (2) @(posedge clk);
        #1 ctl_rst = 0;
        repeat (40) @(posedge clk);
        read_chk(7 * 32 + 31, "R1");

        repeat (FRAME) @(posedge clk);
        read_chk(4 * 32 + 12, "R6");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual still running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule